// File: doc/BRIEF.md
# Memory-Mapped Watchdog Timer

This peripheral guards a system against software that stops making progress. Software loads a reload value, then writes a fixed key to a restart register; that copies the reload value into a 32-bit down counter. The counter runs while the enable bit is set. If software does not write the key again before the counter runs out, the block takes whichever timeout actions are selected. The actions are a system-reset pulse, an interrupt pulse and a pulse on an external watchdog pin. The block also sets a sticky timeout flag, reloads the counter and keeps running.

The counter steps either on every bus-clock cycle or on a 1 MHz tick. The tick comes from a free-running prescaler that divides the bus clock by `CLK_MHZ`, the bus-clock frequency in MHz. A two-bit scope field in the control register drives a separate output. That output tells the reset controller downstream whether a watchdog reset should cover the whole chip or only the SoC. The reset controller itself is not part of this block.

Top module: `tmr_watchdog`

## Requirements
- R1: Registers are decoded from `bus_addr[3:2]` when `bus_addr[1:0]` is 0: index 0 returns the live counter, index 1 the reload value, index 2 (restart) reads as 0, and index 3 returns the control bits in [6:0] with the sticky timeout flag in bit 8. Read data is registered and appears on `bus_rdata` the cycle after `bus_rd`, holding its value until the next read.
- R2: Writing exactly 32'h0000_4755 to index 2 copies the reload value into the counter on that clock edge.
- R3: A write to index 2 with any other value, including 32'h1000_4755, changes neither the counter nor the timeout flag.
- R4: Control bit 0 enables counting. When it is clear, the counter holds its value. Control bits [6:0] read back exactly as written.
- R5: With control bit 4 set, an enabled counter steps once every `CLK_MHZ` bus-clock cycles, on the prescaler tick. With bit 4 clear, it steps on every cycle.
- R6: A step taken while the counter is 0 is an expiry. The counter reloads from the reload register and the timeout flag sets. Only a valid restart key clears the flag.
- R7: On expiry, each output whose select bit was set at that moment pulses high for exactly `PULSE_LEN` cycles, starting the cycle after the expiry. Control bit 1 selects `sys_rst_o`, bit 2 selects `irq_o` and bit 3 selects `ext_o`. Outputs that are not selected stay low.
- R8: `full_chip_o` is high when control bits [6:5] equal 2'b01. Any other value, including 2'b00, means an SoC-only reset and drives it low.
- R9: Writing 0 to control, then a reload value, then the key, then control with enable set starts a fresh countdown from the new reload value.
- R10: After reset the counter and the reload value both equal `RELOAD_INIT`, control and the flag are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_rst_o | output | 1 | System-reset pulse on expiry |
| irq_o | output | 1 | Interrupt pulse on expiry |
| ext_o | output | 1 | External watchdog pulse on expiry |
| full_chip_o | output | 1 | Reset scope: high for a full-chip reset |

## Verification
The hardest case to reach is an expiry in the tick-paced mode, where each counter step waits for a prescaler tick that runs freely and is not aligned with any bus write. The stimulus uses a small divide ratio and a short reload value, so several expiries fall within a few hundred cycles. A behavioural model tracks the prescaler phase from the release of reset. That lets every pulse edge and every counter value read back be predicted to the exact cycle. Bad-key writes and stops are placed between expiries, so that any side effect would show up in the next status read or in the next pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // register word index, taken from bus_addr[3:2]
  localparam logic [1:0] IDX_COUNT  = 2'd0;
  localparam logic [1:0] IDX_RELOAD = 2'd1;
  localparam logic [1:0] IDX_KICK   = 2'd2;
  localparam logic [1:0] IDX_CTRL   = 2'd3;

  localparam logic [31:0] KICK_KEY  = 32'h0000_4755;
  localparam int          FLAG_POS  = 8;
  localparam int          CTRL_W    = 7;

  // control register layout, bit 0 at the bottom
  typedef struct packed {
    logic [1:0] scope;   // 6:5
    logic       slow;    // 4
    logic       act_ext; // 3
    logic       act_irq; // 2
    logic       act_rst; // 1
    logic       run;     // 0
  } ctrl_t;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] ph_q, ph_d;

      always_comb begin
        tick = (ph_q == LAST);
        ph_d = tick ? '0 : ph_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
      end

      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int          W    = 32,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = reload;
    end else if (step) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = reload;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= INIT;
    else         cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load && !step) |=> $stable(cnt_q));
  // R2
  load_takes_reload_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    load |=> cnt_q == $past(reload));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 4,
  parameter int N   = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         fire,
  input  logic [N-1:0] sel,
  output logic [N-1:0] outs
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q, left_d;
  logic [N-1:0]  mask_q, mask_d;

  always_comb begin
    left_d = left_q;
    mask_d = mask_q;
    if (fire) begin
      left_d = LW'(LEN);
      mask_d = sel;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      mask_q <= '0;
    end else begin
      left_q <= left_d;
      mask_q <= mask_d;
    end
  end

  assign outs = (left_q != '0) ? mask_q : '0;

  // R7
  fire_drives_sel_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fire |=> outs == $past(sel));
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog #(
  parameter int          CLK_MHZ     = 125,
  parameter int          PULSE_LEN   = 4,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] RELOAD_INIT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_o,
  output logic              irq_o,
  output logic              ext_o,
  output logic              full_chip_o
);
  import wdt_pkg::*;

  localparam int NACT = 3;

  // reset: asserted asynchronously, released on the clock
  logic sync1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_ni  <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_ni  <= sync1_q;
    end
  end

  // decode
  logic       aligned, wr_ok, kick, reload_we, ctrl_we;
  logic [1:0] idx;
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign idx       = bus_addr[3:2];
  assign wr_ok     = bus_wr && aligned;
  assign kick      = wr_ok && (idx == IDX_KICK) && (bus_wdata == DATA_W'(KICK_KEY));
  assign reload_we = wr_ok && (idx == IDX_RELOAD);
  assign ctrl_we   = wr_ok && (idx == IDX_CTRL);

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] reload_q, reload_d, rdata_q, rdata_d, rd_mux, count;
  logic              flag_q, flag_d, tick, step, expire;
  logic [NACT-1:0]   act_out;

  wdt_tick_gen #(.DIV(CLK_MHZ)) u_tick (
    .clk(clk), .rst_ni(rst_ni), .tick(tick)
  );

  assign step = ctrl_q.run && (ctrl_q.slow ? tick : 1'b1);

  wdt_downcount #(.W(DATA_W), .INIT(DATA_W'(RELOAD_INIT))) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .load(kick), .step(step),
    .reload(reload_q), .count(count), .expire(expire)
  );

  wdt_pulse #(.LEN(PULSE_LEN), .N(NACT)) u_pulse (
    .clk(clk), .rst_ni(rst_ni), .fire(expire),
    .sel({ctrl_q.act_ext, ctrl_q.act_irq, ctrl_q.act_rst}), .outs(act_out)
  );

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (idx)
        IDX_COUNT:  rd_mux = count;
        IDX_RELOAD: rd_mux = reload_q;
        IDX_CTRL: begin
          rd_mux[CTRL_W-1:0] = ctrl_q;
          rd_mux[FLAG_POS]   = flag_q;
        end
        default:    rd_mux = '0;
      endcase
    end
  end

  always_comb begin
    reload_d = reload_we ? bus_wdata : reload_q;
    ctrl_d   = ctrl_we ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    rdata_d  = bus_rd ? rd_mux : rdata_q;
    flag_d   = flag_q;
    if (kick)        flag_d = 1'b0;
    else if (expire) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= DATA_W'(RELOAD_INIT);
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata   = rdata_q;
  assign sys_rst_o   = act_out[0];
  assign irq_o       = act_out[1];
  assign ext_o       = act_out[2];
  assign full_chip_o = (ctrl_q.scope == 2'b01);

  // R6
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    expire |=> flag_q);
  // R3
  bad_key_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_ok && idx == IDX_KICK && !kick && !expire) |=> $stable(flag_q));
  // R7
  rst_unselected_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (expire && !ctrl_q.act_rst) |=> !sys_rst_o);
endmodule

// File: tb/tmr_watchdog_tb_top.sv
module tmr_watchdog_tb_top;
  localparam int          DIV  = 5;
  localparam int          PL   = 3;
  localparam logic [31:0] INIT = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_o, irq_o, ext_o, full_chip_o;

  int    checks = 0, errors = 0;
  string ph = "R10";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  tmr_watchdog #(.CLK_MHZ(DIV), .PULSE_LEN(PL), .DATA_W(32), .RELOAD_INIT(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o), .ext_o(ext_o), .full_chip_o(full_chip_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_sync, m_pre, m_pl;
  logic [31:0] m_cnt, m_rel, m_rdata;
  logic [6:0]  m_ctl;
  logic [2:0]  m_mask;
  logic        m_flag;

  task automatic m_clear();
    m_pre = 0; m_pl = 0; m_cnt = INIT; m_rel = INIT; m_rdata = 0;
    m_ctl = 0; m_mask = 0; m_flag = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_clear();
    end else if (m_sync < 2) begin
      m_sync++; m_clear();
    end else begin
      bit tk, st, hit, kk, ex;
      logic [31:0] ncnt;
      tk  = (m_pre == DIV - 1);
      st  = m_ctl[0] && (m_ctl[4] ? tk : 1'b1);
      hit = (bus_addr[1:0] == 2'b00);
      kk  = bus_wr && hit && bus_addr[3:2] == 2 && bus_wdata == 32'h0000_4755;
      ex  = 1'b0;
      ncnt = m_cnt;
      if (bus_rd) begin
        m_rdata = 0;
        if (hit) begin
          if (bus_addr[3:2] == 0) m_rdata = m_cnt;
          else if (bus_addr[3:2] == 1) m_rdata = m_rel;
          else if (bus_addr[3:2] == 3) m_rdata = {23'd0, m_flag, 1'b0, m_ctl};
        end
      end
      if (kk) begin
        ncnt = m_rel; m_flag = 1'b0;
      end else if (st) begin
        if (m_cnt == 0) begin ex = 1'b1; ncnt = m_rel; m_flag = 1'b1; end
        else ncnt = m_cnt - 1;
      end
      if (ex) begin m_pl = PL; m_mask = m_ctl[3:1]; end
      else if (m_pl > 0) m_pl--;
      if (bus_wr && hit && bus_addr[3:2] == 1) m_rel = bus_wdata;
      if (bus_wr && hit && bus_addr[3:2] == 3) m_ctl = bus_wdata[6:0];
      m_pre = tk ? 0 : m_pre + 1;
      m_cnt = ncnt;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({ph, " R1 rdata"}, bus_rdata, m_rdata);
      chk({ph, " R7 sys_rst"}, {31'd0, sys_rst_o}, {31'd0, (m_pl > 0) && m_mask[0]});
      chk({ph, " R7 irq"}, {31'd0, irq_o}, {31'd0, (m_pl > 0) && m_mask[1]});
      chk({ph, " R7 ext"}, {31'd0, ext_o}, {31'd0, (m_pl > 0) && m_mask[2]});
      chk({ph, " R8 scope"}, {31'd0, full_chip_o}, {31'd0, m_ctl[6:5] == 2'b01});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    idle(3); rst_n = 1'b1; idle(4);

    // R10 reset state
    rd(4'h0, v); chk("R10 count", v, INIT);
    rd(4'h4, v); chk("R10 reload", v, INIT);
    rd(4'hC, v); chk("R10 ctrl", v, 32'd0);
    rd(4'h8, v); chk("R1 restart reads 0", v, 32'd0);

    // R2 key load, bus-clock counting with reset action
    ph = "R2";
    wr(4'h4, 32'd20); wr(4'h8, 32'h0000_4755);
    rd(4'h0, v); chk("R2 count loaded", v, 32'd20);
    wr(4'hC, 32'h03);
    rd(4'hC, v); chk("R4 ctrl readback", v, 32'h03);
    idle(30); rd(4'hC, v); chk("R6 flag set", v[8], 1'b1);
    idle(25);

    // R3 wrong keys ignored
    ph = "R3";
    wr(4'h8, 32'h0000_4754); rd(4'h0, v);
    wr(4'h8, 32'h1000_4755); rd(4'h0, v);
    rd(4'hC, v); chk("R3 flag kept", v[8], 1'b1);
    idle(20);

    // R6 flag cleared by key
    ph = "R6";
    wr(4'h8, 32'h0000_4755); rd(4'hC, v); chk("R6 flag cleared", v[8], 1'b0);

    // R7 action selection
    ph = "R7";
    wr(4'hC, 32'h0F); idle(50);
    wr(4'hC, 32'h05); idle(50);
    wr(4'hC, 32'h09); idle(50);

    // R5 tick-paced counting
    ph = "R5";
    wr(4'h4, 32'd7); wr(4'h8, 32'h0000_4755); wr(4'hC, 32'h17);
    for (int i = 0; i < 6; i++) begin idle(17); rd(4'h0, v); end
    idle(60);

    // R8 scope field
    ph = "R8";
    wr(4'hC, 32'h21); idle(3); chk("R8 full chip", {31'd0, full_chip_o}, 32'd1);
    wr(4'hC, 32'h41); idle(3); chk("R8 code 2 soc", {31'd0, full_chip_o}, 32'd0);
    wr(4'hC, 32'h61); idle(3); chk("R8 code 3 soc", {31'd0, full_chip_o}, 32'd0);

    // R4 stop holds the counter
    ph = "R4";
    wr(4'h4, 32'd1000); wr(4'h8, 32'h0000_4755); idle(10);
    wr(4'hC, 32'h52);
    rd(4'h0, v); idle(20); rd(4'h0, v2); chk("R4 hold", v2, v);
    rd(4'hC, v); chk("R4 ctrl readback", v, 32'h52);

    // R9 start sequence
    ph = "R9";
    wr(4'hC, 32'h0); wr(4'h4, 32'd30); wr(4'h8, 32'h0000_4755); wr(4'hC, 32'h07);
    rd(4'h0, v); chk("R9 fresh count", v, 32'd29);
    idle(80);
    for (int i = 0; i < 4; i++) begin wr(4'h8, 32'h0000_4755); idle(9); rd(4'h0, v); end

    done = 1'b1;
    idle(1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule